// File: doc/BRIEF.md
# Sticky Event Interrupt Collector

This block sits inside a peripheral wrapper on a low-power peripheral bus. It receives event lines from the user logic and detects each rising edge. Each edge sets a bit in a sticky status register. A software-written enable register masks the status, and the masked result gives a pending view. The OR of all pending bits drives one interrupt request line toward the processor. The position of that line within the processor's interrupt vector is a build-time parameter.

Software sees three registers in an interrupt window that begins at offset 0x80 of the wrapper map:

| Offset | Register | Access |
|---|---|---|
| 0x80 | status | read, write-one-to-clear |
| 0x84 | pending | read-only |
| 0x88 | enable | read/write |

A service routine reads the status register and writes the same value back. This clears exactly the events it saw. Register accesses arrive as single-cycle read and write strobes with an address and write data. Read data is combinational during the read strobe.

Top module: `apb_irq_collector`

## Requirements
- R1: The status register is at offset 0x80, the pending register at 0x84 and the enable register at 0x88. A read of any other address returns 0. Each register shows event n in bit n, and all bits at or above NUM_EVT read 0.
- R2: A status bit is set when its event line is high in a cycle and was low in the previous cycle. The bit can be read in the next cycle. A line that stays high sets the bit only once, so clearing the bit while the line is held high leaves it at 0.
- R3: A write to 0x80 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: A rising edge that arrives in the same cycle as a write that clears the same bit wins, and the bit stays 1.
- R5: A write to 0x88 stores data bits [NUM_EVT-1:0] as the enable mask. Higher data bits are dropped and read back as 0.
- R6: The pending register reads status AND enable. It cannot be written: a write to 0x84 changes neither status nor enable.
- R7: The interrupt request is the OR of all pending bits, registered once. It appears on bit IRQ_SEL of the IRQ_LINES-wide output vector. Every other bit of that vector is 0. Seen from a register write, the request changes two clock edges after the write is sampled.
- R8: A synchronous active-low reset clears status, enable and the request. It also clears the stored previous event levels, so an event line that is high when reset ends counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_EVT | Event lines from the user logic |
| reg_addr | input | ADDR_W | Register byte offset within the wrapper |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rd is high, 0 otherwise |
| irq_vec_o | output | IRQ_LINES | Interrupt vector toward the processor, one bit driven |

## Verification
Each result has a fixed delay from its cause:

- Status and enable follow an event edge or a register write at the next clock edge. A read issued in the following cycle therefore already shows the new value.
- The interrupt output adds one more register on top of that. It is checked two cycles after the write or event that causes the change.

The bench drives every input at the falling edge. A scoreboard queue holds each expected value, and the monitor compares it 1 ns after the falling edge of the same cycle, away from the sampling edge. Every stimulus task takes exactly one cycle, so the delays above hold by counting tasks.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared constants of the interrupt collector: register byte offsets.
// Assumes the wrapper address is at least 8 bits wide.
package irqc_pkg;
    localparam logic [7:0] OFS_STATUS  = 8'h80;
    localparam logic [7:0] OFS_PENDING = 8'h84;
    localparam logic [7:0] OFS_ENABLE  = 8'h88;
endpackage

// File: rtl/irqc_event_latch.sv
`timescale 1ns/1ps
// Event latch: detects rising edges on each event line and holds them
// in a sticky status bit. A write-one-to-clear request drops bits,
// but an edge arriving in the same cycle keeps its bit set.
// Assumes events are already synchronous to clk.
module irqc_event_latch #(
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_we,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] stat_o
);
    logic [NUM_EVT-1:0] evt_prev;
    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] clr_eff;

    // Previous event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= '0;
        else        evt_prev <= evt_i;
    end

    // Rising edges this cycle, and the clear mask only while a write is active.
    always_comb begin
        rise    = evt_i & ~evt_prev;
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Sticky status: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= rise | (stat_o & ~clr_eff);
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
        // R2 R4
        stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> stat_o[i]);
        // R3
        stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[i] && !rise[i]) |=> !stat_o[i]);
        // R3
        stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_eff[i] && !rise[i]) |=> (stat_o[i] == $past(stat_o[i])));
    end
endmodule

// File: rtl/irqc_enable_reg.sv
`timescale 1ns/1ps
// Enable mask register. It loads the low NUM_EVT data bits when written.
// Assumes a one-cycle write strobe. Resets to all zeros.
module irqc_enable_reg #(
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] en_o
);
    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_o <= '0;
        else if (we) en_o <= wdata;
    end

    // R8
    en_reset_chk: assert property (@(posedge clk) !rst_n |=> (en_o == '0));
    // R5
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en_o == $past(wdata)));
endmodule

// File: rtl/irqc_irq_route.sv
`timescale 1ns/1ps
// Request stage: registers the OR of the pending bits and places it on
// one selected line of the processor interrupt vector. The other lines
// are tied to 0. Assumes IRQ_SEL < IRQ_LINES.
module irqc_irq_route #(
    parameter int NUM_EVT   = 2,
    parameter int IRQ_LINES = 16,
    parameter int IRQ_SEL   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   pend_i,
    output logic [IRQ_LINES-1:0] irq_vec_o
);
    logic irq_q;

    // One register stage on the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_i;
    end

    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
        if (g == IRQ_SEL) begin : g_hit
            assign irq_vec_o[g] = irq_q;
        end else begin : g_tie
            assign irq_vec_o[g] = 1'b0;
        end
    end

    // R7
    irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_vec_o[IRQ_SEL] == $past(|pend_i)));
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_vec_o));
endmodule

// File: rtl/apb_irq_collector.sv
`timescale 1ns/1ps
// Interrupt collector for a peripheral wrapper. It decodes the interrupt
// register window (status, pending, enable), latches user events and
// raises one registered request. Assumes NUM_EVT <= DATA_W, ADDR_W >= 8,
// and single-cycle, mutually independent read and write strobes.
module apb_irq_collector #(
    parameter int NUM_EVT   = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int IRQ_LINES = 16,
    parameter int IRQ_SEL   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [IRQ_LINES-1:0] irq_vec_o
);
    import irqc_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(OFS_ENABLE);

    logic               hit_stat, hit_pend, hit_enab;
    logic [NUM_EVT-1:0] stat, enab, pend;

    // Address decode of the interrupt window.
    always_comb begin
        hit_stat = (reg_addr == A_STAT);
        hit_pend = (reg_addr == A_PEND);
        hit_enab = (reg_addr == A_ENAB);
    end

    irqc_event_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_we   (reg_wr && hit_stat),
        .clr_mask (reg_wdata[NUM_EVT-1:0]),
        .stat_o   (stat)
    );

    irqc_enable_reg #(.NUM_EVT(NUM_EVT)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wr && hit_enab),
        .wdata (reg_wdata[NUM_EVT-1:0]),
        .en_o  (enab)
    );

    // Masked view of the status.
    always_comb pend = stat & enab;

    irqc_irq_route #(
        .NUM_EVT   (NUM_EVT),
        .IRQ_LINES (IRQ_LINES),
        .IRQ_SEL   (IRQ_SEL)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .irq_vec_o (irq_vec_o)
    );

    // Read multiplexer, zero outside a read or outside the window.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_stat)      reg_rdata[NUM_EVT-1:0] = stat;
            else if (hit_pend) reg_rdata[NUM_EVT-1:0] = pend;
            else if (hit_enab) reg_rdata[NUM_EVT-1:0] = enab;
        end
    end

    // R6
    pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_pend) |=> (enab == $past(enab)));
    // R1
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/test_apb_irq_collector.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values into a queue and
// one monitor pops and compares them 1 ns after each falling edge.
module test_apb_irq_collector;
    localparam int NE = 2, DW = 32, AW = 8, NL = 16, SEL = 3;
    localparam logic [NL-1:0] IRQ_ON = NL'(1) << SEL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NL-1:0] irq;
    logic          probe_rd = 1'b0, probe_irq = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    apb_irq_collector #(
        .NUM_EVT(NE), .DATA_W(DW), .ADDR_W(AW), .IRQ_LINES(NL), .IRQ_SEL(SEL)
    ) i_apb_irq_collector (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq_vec_o(irq)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: compares each probed cycle against the head of the queue.
    initial forever begin
        @(negedge clk);
        #1;
        if (probe_rd || probe_irq) begin
            item_t it;
            logic [31:0] act;
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: act=%h exp=none", rdata);
            end else begin
                it = sb.pop_front();
                act = it.is_irq ? 32'(irq) : rdata;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // One cycle: drive the strobes and the event lines, no check.
    task automatic step(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NE-1:0] e);
        @(negedge clk);
        wr = w; rd = 1'b0; addr = a; wdata = d; evt = e;
        probe_rd = 1'b0; probe_irq = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp,
                          input string tag);
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = a; probe_rd = 1'b1; probe_irq = 1'b0;
        sb.push_back('{1'b0, exp, tag});
    endtask

    task automatic irq_chk(input logic [NL-1:0] exp, input string tag);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; probe_rd = 1'b0; probe_irq = 1'b1;
        sb.push_back('{1'b1, 32'(exp), tag});
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; rd = 1'b0; probe_rd = 1'b0; probe_irq = 1'b0;
        for (int i = 0; i < cycles; i++) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        report();
    end

    initial begin
        do_reset(4);
        // R8: reset values of every register and the request
        rd_chk(8'h80, 0, "R8 status after reset");
        rd_chk(8'h88, 0, "R8 enable after reset");
        rd_chk(8'h84, 0, "R8 pending after reset");
        irq_chk('0, "R8 irq after reset");
        // R2: an edge on event 0 sets status; masked, so no request
        step(1'b0, 8'h00, 0, 2'b01);
        rd_chk(8'h80, 32'h1, "R2 status after edge");
        rd_chk(8'h84, 0, "R6 pending with enable off");
        irq_chk('0, "R7 irq masked");
        // R5: enable write keeps only the low bits
        step(1'b1, 8'h88, 32'hFFFF_FFFF, 2'b01);
        rd_chk(8'h88, 32'h3, "R5 enable width");
        irq_chk(IRQ_ON, "R7 irq on selected line");
        rd_chk(8'h84, 32'h1, "R6 pending view");
        // R2 R3: clearing with the line still high leaves the bit at 0
        step(1'b1, 8'h80, 32'h1, 2'b01);
        rd_chk(8'h80, 0, "R2 R3 level does not re-set");
        irq_chk('0, "R7 irq drops after clear");
        // R3: writing 0 keeps status, writing 1 clears only that bit
        step(1'b0, 8'h00, 0, 2'b11);
        rd_chk(8'h80, 32'h2, "R2 second event edge");
        step(1'b1, 8'h80, 32'h0, 2'b11);
        rd_chk(8'h80, 32'h2, "R3 zero write keeps");
        step(1'b1, 8'h80, 32'h2, 2'b11);
        rd_chk(8'h80, 0, "R3 one write clears");
        // R4: an edge in the same cycle as a clear wins
        step(1'b0, 8'h00, 0, 2'b00);
        step(1'b0, 8'h00, 0, 2'b01);
        step(1'b0, 8'h00, 0, 2'b00);
        step(1'b1, 8'h80, 32'h1, 2'b01);
        rd_chk(8'h80, 32'h1, "R4 set beats clear");
        step(1'b1, 8'h80, 32'h1, 2'b01);
        rd_chk(8'h80, 0, "R3 clear without edge");
        // R6: a write to pending touches nothing
        step(1'b0, 8'h00, 0, 2'b10);
        step(1'b1, 8'h84, 32'hFFFF_FFFF, 2'b10);
        rd_chk(8'h80, 32'h2, "R6 status after pending write");
        rd_chk(8'h88, 32'h3, "R6 enable after pending write");
        rd_chk(8'h84, 32'h2, "R6 pending value");
        // R1: unmapped offsets read zero
        rd_chk(8'h8C, 0, "R1 unmapped 0x8C");
        rd_chk(8'h00, 0, "R1 unmapped 0x00");
        // R7: disabling all sources drops the request two edges later
        step(1'b1, 8'h88, 32'h0, 2'b10);
        rd_chk(8'h84, 0, "R6 pending after disable");
        irq_chk('0, "R7 irq after disable");
        // R8: reset mid-run; event 1 held high counts as an edge after reset
        step(1'b1, 8'h88, 32'h3, 2'b10);
        do_reset(2);
        rd_chk(8'h88, 0, "R8 enable cleared");
        rd_chk(8'h80, 32'h2, "R8 high line after reset is an edge");
        rd_chk(8'h84, 0, "R8 pending cleared");
        irq_chk('0, "R8 irq cleared");
        step(1'b0, 8'h00, 0, 2'b10);
        step(1'b0, 8'h00, 0, 2'b10);
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
        end
        report();
    end
endmodule